// File: doc/BRIEF.md
# Downstream Port Power and Indicator Controller

This block sits beside the four downstream ports of a hub. It takes power requests for each port from the hub's control registers and turns them into active-low power-switch enables. It watches active-low over-current flags from the external switches and removes power when a fault is confirmed. It also drives a green and an amber indicator lamp for every port.

A strap input picks how power is managed. In individual mode each port has its own switch and its own fault flag. In ganged mode a single switch and a single fault flag, both on channel 0, serve the four ports as one group. A confirmed fault latches a change bit, which software clears. Power comes back only after the port's request is dropped and raised again.

Each lamp pair follows the port status on its own or shows a colour that the host picks. A global-suspend flag turns every lamp off. A flag that marks an attached configuration EEPROM holds all amber outputs low, because the amber lines double as EEPROM access lines.

Top module: `hub_port_power`

## Requirements
- R1: While reset is low and in the first cycle after it, every power enable is high (off), every change bit is 0, and with all ports in automatic lamp mode every green and amber output is 0.
- R2: In individual mode, a rising edge on a port's request bit drives that port's power enable low within three clock cycles, and dropping the request drives it high again.
- R3: An over-current input passes through a two-stage synchronizer. It is acted on only after it has stayed low for DEBOUNCE_CYCLES consecutive synchronized cycles. A shorter low pulse changes no output.
- R4: In individual mode, a confirmed fault on port i drives only power enable i high and sets only change bit i. The port stays unpowered while its request remains high, even after the fault flag goes away, until the request goes low and then high again.
- R5: A change bit stays set until a one-cycle pulse on its bit of oc_clr_i. Clearing it does not restore power.
- R6: In ganged mode only power enable 0 is used: it goes low on a rising edge of the OR of all request bits, enables 3..1 stay high, and over-current inputs 3..1 are ignored.
- R7: In ganged mode, a confirmed fault on over-current input 0 removes group power and sets all four change bits.
- R8: In automatic lamp mode (led_manual_i bit = 0) a port shows amber while its change bit is set, otherwise green while it is powered, otherwise nothing. In ganged mode every port counts as powered while the group is powered.
- R9: In manual lamp mode the port's two-bit selector in led_sel_i[2i+1:2i] means 00 off, 01 amber, 10 green, 11 green blinking. The blink phase toggles every BLINK_HALF_CYCLES clock cycles.
- R10: While suspend_i is high every green and amber output is 0, and power and change state are left untouched.
- R11: While eeprom_present_i is high every amber output is 0, and the green outputs are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gang_mode_i | input | 1 | 1 selects ganged power control, 0 selects individual |
| oc_n_i | input | 4 | Over-current flags from the port switches, active low |
| pwr_req_i | input | 4 | Port power requests from the hub control registers |
| oc_clr_i | input | 4 | One-cycle pulses that clear change bits |
| led_manual_i | input | 4 | 1 puts a port's lamps under host control |
| led_sel_i | input | 8 | Manual colour selector, two bits per port |
| suspend_i | input | 1 | Hub is globally suspended |
| eeprom_present_i | input | 1 | A configuration EEPROM is attached |
| pwr_en_n_o | output | 4 | Power switch enables, active low |
| oc_change_o | output | 4 | Latched over-current change bits |
| green_o | output | 4 | Green lamp drive |
| amber_o | output | 4 | Amber lamp drive |

## Verification
The bench sends an over-current pulse one cycle shorter than the debounce window. A filter that counts badly would then cut power that should stay on. It checks that power stays off after the fault flag is released while the request is still held, which catches a design that re-powers on the level of the request instead of on its edge. It drives faults on inputs 3..1 in ganged mode, where a design that does not mask them would cut group power. It also drives a fault on input 0, which must set all four change bits and not just one. The lamp overrides are checked on top of lamps that are actually lit, and the blink rate is measured over a window, so a wrong divider or an override in the wrong order shows up as a count mismatch.

// File: rtl/hub_port_power_pkg.sv
// Shared types for the downstream port power and indicator block.
package hub_port_power_pkg;

    // Manual lamp selector codes, two bits per port.
    typedef enum logic [1:0] {
        SEL_OFF   = 2'b00,
        SEL_AMBER = 2'b01,
        SEL_GREEN = 2'b10,
        SEL_BLINK = 2'b11
    } led_sel_e;

    // Drive for one port's lamp pair.
    typedef struct packed {
        logic green;
        logic amber;
    } lamp_t;

endpackage

// File: rtl/oc_filter.sv
// Over-current qualifier for one channel.
// Brings the active-low flag into the clock domain through two flops, then
// requires DEBOUNCE_CYCLES consecutive asserted samples. It emits a single
// one-cycle event per qualified assertion.
// Assumes DEBOUNCE_CYCLES >= 2.
module oc_filter #(
    parameter int DEBOUNCE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_n_i,
    output logic fault_evt_o
);
    localparam int CW = $clog2(DEBOUNCE_CYCLES + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_q;

    // Two-stage synchronizer, stored as active-high fault.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[0], ~fault_n_i};
    end

    // Count consecutive asserted samples, saturating at the window length.
    always_ff @(posedge clk) begin
        if (!rst_n)                           run_q <= '0;
        else if (!sync_q[1])                  run_q <= '0;
        else if (run_q != CW'(DEBOUNCE_CYCLES)) run_q <= run_q + 1'b1;
    end

    assign fault_evt_o = sync_q[1] && (run_q == CW'(DEBOUNCE_CYCLES - 1));

endmodule

// File: rtl/port_power_ctl.sv
// Power state and fault latches for all ports.
// Individual mode: one power flag per port. Ganged mode: one group flag
// driven by channel 0. Power turns on at a rising request edge, turns off
// when the request drops or a fault event arrives. Change bits are set by
// faults and cleared by software pulses, and a set wins over a clear.
// Assumes gang_mode_i changes only while reset is asserted.
module port_power_ctl #(
    parameter int NUM_PORTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 gang_mode_i,
    input  logic [NUM_PORTS-1:0] pwr_req_i,
    input  logic [NUM_PORTS-1:0] oc_clr_i,
    input  logic [NUM_PORTS-1:0] fault_evt_i,
    output logic [NUM_PORTS-1:0] powered_o,
    output logic [NUM_PORTS-1:0] pwr_en_n_o,
    output logic [NUM_PORTS-1:0] oc_change_o
);
    logic [NUM_PORTS-1:0] req_q;
    logic [NUM_PORTS-1:0] ind_on_q;
    logic [NUM_PORTS-1:0] chg_q;
    logic [NUM_PORTS-1:0] fault_hit;
    logic                 any_req;
    logic                 any_req_q;
    logic                 gang_on_q;

    assign any_req = |pwr_req_i;

    // Remember last request levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q     <= '0;
            any_req_q <= 1'b0;
        end else begin
            req_q     <= pwr_req_i;
            any_req_q <= any_req;
        end
    end

    // Group power flag used in ganged mode.
    always_ff @(posedge clk) begin
        if (!rst_n)              gang_on_q <= 1'b0;
        else if (fault_evt_i[0]) gang_on_q <= 1'b0;
        else if (!any_req)       gang_on_q <= 1'b0;
        else if (!any_req_q)     gang_on_q <= 1'b1;
    end

    generate
        for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
            // Route the fault that applies to this port.
            assign fault_hit[i] = gang_mode_i ? fault_evt_i[0] : fault_evt_i[i];

            // Per-port power flag used in individual mode.
            always_ff @(posedge clk) begin
                if (!rst_n)              ind_on_q[i] <= 1'b0;
                else if (fault_evt_i[i]) ind_on_q[i] <= 1'b0;
                else if (!pwr_req_i[i])  ind_on_q[i] <= 1'b0;
                else if (!req_q[i])      ind_on_q[i] <= 1'b1;
            end

            // Change latch: set by a fault, cleared by software.
            always_ff @(posedge clk) begin
                if (!rst_n)            chg_q[i] <= 1'b0;
                else if (fault_hit[i]) chg_q[i] <= 1'b1;
                else if (oc_clr_i[i])  chg_q[i] <= 1'b0;
            end

            // Powered status and switch enable for this port.
            always_comb begin
                powered_o[i] = gang_mode_i ? gang_on_q : ind_on_q[i];
                if (i == 0) pwr_en_n_o[i] = gang_mode_i ? ~gang_on_q : ~ind_on_q[i];
                else        pwr_en_n_o[i] = gang_mode_i ? 1'b1 : ~ind_on_q[i];
            end
        end
    endgenerate

    assign oc_change_o = chg_q;

endmodule

// File: rtl/indicator_drv.sv
// Lamp drive for all ports.
// Automatic mode shows amber for a latched fault, green for a powered port.
// Manual mode decodes the host selector. One shared divider makes the blink
// phase. Suspend blanks every lamp, and an attached EEPROM blanks amber.
// Assumes BLINK_HALF_CYCLES >= 2.
module indicator_drv
    import hub_port_power_pkg::*;
#(
    parameter int NUM_PORTS         = 4,
    parameter int BLINK_HALF_CYCLES = 3_000_000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_PORTS-1:0]   powered_i,
    input  logic [NUM_PORTS-1:0]   change_i,
    input  logic [NUM_PORTS-1:0]   led_manual_i,
    input  logic [2*NUM_PORTS-1:0] led_sel_i,
    input  logic                   suspend_i,
    input  logic                   eeprom_present_i,
    output logic [NUM_PORTS-1:0]   green_o,
    output logic [NUM_PORTS-1:0]   amber_o
);
    localparam int BW = $clog2(BLINK_HALF_CYCLES);

    logic [BW-1:0] div_q;
    logic          phase_q;

    // Free-running divider that toggles the blink phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q   <= '0;
            phase_q <= 1'b0;
        end else if (div_q == BW'(BLINK_HALF_CYCLES - 1)) begin
            div_q   <= '0;
            phase_q <= ~phase_q;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    generate
        for (genvar i = 0; i < NUM_PORTS; i++) begin : g_lamp
            lamp_t    lamp;
            led_sel_e sel;

            assign sel = led_sel_e'(led_sel_i[2*i +: 2]);

            // Pick the colour, then apply the suspend and EEPROM overrides.
            always_comb begin
                lamp = '0;
                if (led_manual_i[i]) begin
                    case (sel)
                        SEL_AMBER: lamp.amber = 1'b1;
                        SEL_GREEN: lamp.green = 1'b1;
                        SEL_BLINK: lamp.green = phase_q;
                        default:   lamp = '0;
                    endcase
                end else if (change_i[i]) begin
                    lamp.amber = 1'b1;
                end else if (powered_i[i]) begin
                    lamp.green = 1'b1;
                end
                if (suspend_i)        lamp = '0;
                if (eeprom_present_i) lamp.amber = 1'b0;
                green_o[i] = lamp.green;
                amber_o[i] = lamp.amber;
            end
        end
    endgenerate

endmodule

// File: rtl/hub_port_power.sv
// Top of the downstream port power and indicator controller.
// One over-current filter per port feeds the power/latch stage, which feeds
// the lamp driver. The ganged/individual strap is static outside reset.
module hub_port_power #(
    parameter int NUM_PORTS         = 4,
    parameter int DEBOUNCE_CYCLES   = 16,
    parameter int BLINK_HALF_CYCLES = 3_000_000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   gang_mode_i,
    input  logic [NUM_PORTS-1:0]   oc_n_i,
    input  logic [NUM_PORTS-1:0]   pwr_req_i,
    input  logic [NUM_PORTS-1:0]   oc_clr_i,
    input  logic [NUM_PORTS-1:0]   led_manual_i,
    input  logic [2*NUM_PORTS-1:0] led_sel_i,
    input  logic                   suspend_i,
    input  logic                   eeprom_present_i,
    output logic [NUM_PORTS-1:0]   pwr_en_n_o,
    output logic [NUM_PORTS-1:0]   oc_change_o,
    output logic [NUM_PORTS-1:0]   green_o,
    output logic [NUM_PORTS-1:0]   amber_o
);
    logic [NUM_PORTS-1:0] fault_evt;
    logic [NUM_PORTS-1:0] powered;

    generate
        for (genvar i = 0; i < NUM_PORTS; i++) begin : g_filt
            oc_filter #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) u_filt (
                .clk         (clk),
                .rst_n       (rst_n),
                .fault_n_i   (oc_n_i[i]),
                .fault_evt_o (fault_evt[i])
            );
        end
    endgenerate

    port_power_ctl #(.NUM_PORTS(NUM_PORTS)) u_pwr (
        .clk         (clk),
        .rst_n       (rst_n),
        .gang_mode_i (gang_mode_i),
        .pwr_req_i   (pwr_req_i),
        .oc_clr_i    (oc_clr_i),
        .fault_evt_i (fault_evt),
        .powered_o   (powered),
        .pwr_en_n_o  (pwr_en_n_o),
        .oc_change_o (oc_change_o)
    );

    indicator_drv #(
        .NUM_PORTS         (NUM_PORTS),
        .BLINK_HALF_CYCLES (BLINK_HALF_CYCLES)
    ) u_ind (
        .clk              (clk),
        .rst_n            (rst_n),
        .powered_i        (powered),
        .change_i         (oc_change_o),
        .led_manual_i     (led_manual_i),
        .led_sel_i        (led_sel_i),
        .suspend_i        (suspend_i),
        .eeprom_present_i (eeprom_present_i),
        .green_o          (green_o),
        .amber_o          (amber_o)
    );

endmodule

// File: rtl/hub_port_power_chk.sv
// Property checker for hub_port_power, attached through bind.
module hub_port_power_chk #(
    parameter int NUM_PORTS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 gang_mode_i,
    input logic [NUM_PORTS-1:0] pwr_req_i,
    input logic [NUM_PORTS-1:0] oc_clr_i,
    input logic                 suspend_i,
    input logic                 eeprom_present_i,
    input logic [NUM_PORTS-1:0] pwr_en_n_o,
    input logic [NUM_PORTS-1:0] oc_change_o,
    input logic [NUM_PORTS-1:0] green_o,
    input logic [NUM_PORTS-1:0] amber_o
);
    // R6
    gang_unused_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gang_mode_i |-> (&pwr_en_n_o[NUM_PORTS-1:1]));

    // R10
    suspend_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_i |-> (green_o == '0 && amber_o == '0));

    // R11
    eeprom_amber_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eeprom_present_i |-> (amber_o == '0));

    // R5
    change_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((oc_change_o & ~oc_clr_i) != '0) |=>
        ((($past(oc_change_o) & ~$past(oc_clr_i)) & ~oc_change_o) == '0));

    // R4
    fault_cuts_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gang_mode_i && ((oc_change_o & ~$past(oc_change_o)) != '0)) |->
        (((oc_change_o & ~$past(oc_change_o)) & ~pwr_en_n_o) == '0));

    // R2
    power_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gang_mode_i |=> ((~pwr_en_n_o & ~$past(pwr_req_i)) == '0));

endmodule

bind hub_port_power hub_port_power_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .gang_mode_i      (gang_mode_i),
    .pwr_req_i        (pwr_req_i),
    .oc_clr_i         (oc_clr_i),
    .suspend_i        (suspend_i),
    .eeprom_present_i (eeprom_present_i),
    .pwr_en_n_o       (pwr_en_n_o),
    .oc_change_o      (oc_change_o),
    .green_o          (green_o),
    .amber_o          (amber_o)
);

// File: tb/hub_port_power_bench.sv
module hub_port_power_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEB        = 6;
    localparam int BLINK      = 5;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       gang_mode_i;
    logic [3:0] oc_n_i, pwr_req_i, oc_clr_i, led_manual_i;
    logic [7:0] led_sel_i;
    logic       suspend_i, eeprom_present_i;
    logic [3:0] pwr_en_n_o, oc_change_o, green_o, amber_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        string      req;
        logic [3:0] pwr_n;
        logic [3:0] chg;
        logic [3:0] grn;
        logic [3:0] amb;
    } exp_t;

    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    hub_port_power #(
        .NUM_PORTS(4), .DEBOUNCE_CYCLES(DEB), .BLINK_HALF_CYCLES(BLINK)
    ) u_hub_port_power (
        .clk(clk), .rst_n(rst_n), .gang_mode_i(gang_mode_i), .oc_n_i(oc_n_i),
        .pwr_req_i(pwr_req_i), .oc_clr_i(oc_clr_i), .led_manual_i(led_manual_i),
        .led_sel_i(led_sel_i), .suspend_i(suspend_i),
        .eeprom_present_i(eeprom_present_i), .pwr_en_n_o(pwr_en_n_o),
        .oc_change_o(oc_change_o), .green_o(green_o), .amber_o(amber_o)
    );

    task automatic check_val(string req, string what, int act, int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Monitor: compare the oldest expectation at a falling edge, then retire it.
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                check_val(exp_q[0].req, "pwr_en_n", int'(pwr_en_n_o), int'(exp_q[0].pwr_n));
                check_val(exp_q[0].req, "change",   int'(oc_change_o), int'(exp_q[0].chg));
                check_val(exp_q[0].req, "green",    int'(green_o),     int'(exp_q[0].grn));
                check_val(exp_q[0].req, "amber",    int'(amber_o),     int'(exp_q[0].amb));
                void'(exp_q.pop_front());
            end
        end
    end

    // Driver side: queue an expectation and wait until the monitor retires it.
    task automatic expect_out(string req, logic [3:0] p, logic [3:0] c,
                              logic [3:0] g, logic [3:0] a);
        exp_t e;
        e.req = req; e.pwr_n = p; e.chg = c; e.grn = g; e.amb = a;
        exp_q.push_back(e);
        wait (exp_q.size() == 0);
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(logic gang);
        rst_n = 1'b0; gang_mode_i = gang; oc_n_i = 4'hF; pwr_req_i = 4'h0;
        oc_clr_i = 4'h0; led_manual_i = 4'h0; led_sel_i = 8'h00;
        suspend_i = 1'b0; eeprom_present_i = 1'b0;
        cycles(4);
        rst_n = 1'b1;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int highs, edges;
        logic prev;
        @(negedge clk);
        do_reset(1'b0);
        // R1 reset state
        expect_out("R1", 4'hF, 4'h0, 4'h0, 4'h0);

        // R2 power on two ports, R8 automatic green
        pwr_req_i = 4'b0101; cycles(3);
        expect_out("R2", 4'b1010, 4'h0, 4'b0101, 4'h0);

        // R3 glitch one cycle shorter than the window
        oc_n_i[0] = 1'b0; cycles(DEB - 1); oc_n_i[0] = 1'b1; cycles(10);
        expect_out("R3", 4'b1010, 4'h0, 4'b0101, 4'h0);

        // R4 fault on port 2 only, R8 amber
        oc_n_i[2] = 1'b0; cycles(DEB + 6);
        expect_out("R4", 4'b1110, 4'b0100, 4'b0001, 4'b0100);
        oc_n_i[2] = 1'b1; cycles(6);
        expect_out("R4", 4'b1110, 4'b0100, 4'b0001, 4'b0100);

        // R5 clear does not restore power
        oc_clr_i[2] = 1'b1; cycles(1); oc_clr_i[2] = 1'b0; cycles(3);
        expect_out("R5", 4'b1110, 4'h0, 4'b0001, 4'h0);

        // R4 re-request brings port 2 back
        pwr_req_i[2] = 1'b0; cycles(2); pwr_req_i[2] = 1'b1; cycles(3);
        expect_out("R4", 4'b1010, 4'h0, 4'b0101, 4'h0);

        // R11 fault on port 0 lights amber, EEPROM blanks it
        oc_n_i[0] = 1'b0; cycles(DEB + 6);
        expect_out("R8", 4'b1011, 4'b0001, 4'b0100, 4'b0001);
        eeprom_present_i = 1'b1; cycles(1);
        expect_out("R11", 4'b1011, 4'b0001, 4'b0100, 4'h0);
        eeprom_present_i = 1'b0; oc_n_i[0] = 1'b1;

        // R10 suspend blanks lamps, keeps state
        suspend_i = 1'b1; cycles(2);
        expect_out("R10", 4'b1011, 4'b0001, 4'h0, 4'h0);
        suspend_i = 1'b0;
        oc_clr_i[0] = 1'b1; cycles(1); oc_clr_i[0] = 1'b0; cycles(2);

        // R9 manual selectors: p0 off, p1 amber, p2 green, p3 off
        led_manual_i = 4'hF; led_sel_i = 8'b00_10_01_00; cycles(1);
        expect_out("R9", 4'b1011, 4'h0, 4'b0100, 4'b0010);

        // R9 blink on port 3
        led_sel_i = 8'b11_10_01_00;
        highs = 0; edges = 0; cycles(1); prev = green_o[3];
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (green_o[3]) highs++;
            if (green_o[3] != prev) edges++;
            prev = green_o[3];
            if (amber_o[3]) check_val("R9", "blink amber", 1, 0);
        end
        checks++;
        if (edges < 7 || edges > 9) begin
            fails++;
            $display("FAIL R9 blink toggles actual=%0d expected=8", edges);
        end
        checks++;
        if (highs < 15 || highs > 25) begin
            fails++;
            $display("FAIL R9 blink high count actual=%0d expected=20", highs);
        end

        // R6 ganged mode: group power on channel 0
        do_reset(1'b1); cycles(1);
        pwr_req_i = 4'b0010; cycles(3);
        expect_out("R6", 4'b1110, 4'h0, 4'hF, 4'h0);
        oc_n_i[3:1] = 3'b000; cycles(DEB + 6);
        expect_out("R6", 4'b1110, 4'h0, 4'hF, 4'h0);
        oc_n_i[3:1] = 3'b111;

        // R7 fault on channel 0 hits the whole group
        oc_n_i[0] = 1'b0; cycles(DEB + 6);
        expect_out("R7", 4'hF, 4'hF, 4'h0, 4'hF);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule